// File: doc/BRIEF.md
# Interrupt Distributor Global Control Words

This block is the small register file that holds the global control and identification words of an interrupt distributor. A 32-bit, word-aligned register bus reads and writes three words, chosen by address bits [3:2]: a control word carrying the distributor-wide enable, a type word that describes the configuration (interrupt line count and CPU count), and a constant identification word. When the global enable goes from off to on, the block sends a one-cycle wake pulse to every CPU, so that work held back while the distributor was off gets looked at again.

A second, privileged configuration port reaches the same words and also a per-interrupt group bit array. Writes to the group array are dropped until the privileged side has written the identification word with exactly the value it reads back. That write sets a sticky unlock flag. A write with any other value is refused and flagged with a one-cycle error pulse. Priority, pending state and routing live elsewhere. The block only exposes the group bits and the enable as outputs for that logic.

Top module: `irq_dist_ctrl`

## Requirements
- R1: Bus read data depends only on bus address bits [3:2]: 0 returns the control word, 1 the type word, 2 the identification word and 3 returns zero. Address bits [1:0] have no effect.
- R2: Control word bit 0 is the global enable. A bus write to word 0 loads it from write-data bit 0, and the new value is visible on `dist_en` and in readback after that clock edge. All other control bits read as zero.
- R3: When the enable goes from 0 to 1, `wake_pulse` is all ones for exactly one cycle. It rises at the same edge as `dist_en`, and all CPU bits are always equal.
- R4: Writing 1 to an enable that is already 1, or writing 0, produces no wake pulse.
- R5: The type word is (NUM_IRQ/32 - 1) in bits [4:0] and (NUM_CPU - 1) in bits [7:5], with zero above. For NUM_IRQ=96 and NUM_CPU=4 it is 0x62.
- R6: The identification word is PRODUCT_ID in bits [31:24], REVISION in bits [15:12] and IMPLEMENTER in bits [11:0]. Bus writes to words 1, 2 and 3 change nothing.
- R7: A privileged write (`cfg_space`=0) to word 2 whose data differs from the identification word raises `cfg_err` for one cycle and leaves the group array locked.
- R8: A privileged write to word 2 with data equal to the identification word sets `group_unlocked` from the next edge on, and it stays set until reset. No error is raised.
- R9: While `group_unlocked` is 0, privileged group writes (`cfg_space`=1) leave `grp_bits` unchanged.
- R10: Once unlocked, a privileged group write replaces the 32 group bits of word index `cfg_addr[CFG_AW-1:2]`, which are bits [32*i+31:32*i]. An index at or beyond NUM_IRQ/32 is dropped.
- R11: Reset clears the enable, the unlock flag, the group bits and `cfg_err`, and no wake pulse appears while reset is asserted.
- R12: A privileged write to word 0 loads the enable in the same way as a bus write, with the same wake rule. When both ports write word 0 in the same cycle, the privileged value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | BUS_AW | Bus byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data for `bus_addr` (combinational) |
| cfg_we | input | 1 | Privileged write strobe |
| cfg_space | input | 1 | 0: control words, 1: group bit array |
| cfg_addr | input | CFG_AW | Privileged byte address (word in bits [3:2], or group word index in [CFG_AW-1:2]) |
| cfg_wdata | input | 32 | Privileged write data |
| cfg_err | output | 1 | One-cycle pulse: rejected identification write |
| dist_en | output | 1 | Global enable |
| wake_pulse | output | NUM_CPU | One-cycle wake to every CPU on enable rise |
| group_unlocked | output | 1 | Sticky group-write unlock flag |
| grp_bits | output | NUM_IRQ | Per-interrupt group bits |

## Verification
The bench goes after the edge of the enable. A design that pulses on level instead of on a rise would wake the CPUs again on a repeated write of 1. One that compared against the wrong past value would miss the pulse or stretch it to two cycles. It sweeps every low address nibble, because a decode that used bits [1:0] or wrapped the unused offset would return stale words. It also writes junk to the read-only words to catch a design that lets them change. On the privileged side it tries group writes before unlock, after a mismatching identification write and after a matching one. It then writes every group index including the one beyond the array, which catches a design that unlocks on any write, drops the stickiness, or aliases the out-of-range index onto a real word. Simultaneous writes from both ports and a mid-run reset close the set.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

   typedef enum logic [1:0] {
      WSEL_CTRL  = 2'd0,
      WSEL_TYPE  = 2'd1,
      WSEL_IDENT = 2'd2,
      WSEL_NONE  = 2'd3
   } word_sel_t;

   localparam int unsigned EN_BIT        = 0;
   localparam int unsigned LINES_PER_WORD = 32;
   localparam int unsigned TYPE_CPU_LSB  = 5;
   localparam int unsigned TYPE_CPU_W    = 3;
   localparam int unsigned TYPE_LINE_W   = 5;

   function automatic logic [31:0] make_type_word(input int unsigned lines,
                                                  input int unsigned cpus);
      logic [31:0] w;
      w = '0;
      w[TYPE_LINE_W-1:0] = TYPE_LINE_W'(lines / LINES_PER_WORD - 1);
      w[TYPE_CPU_LSB +: TYPE_CPU_W] = TYPE_CPU_W'(cpus - 1);
      return w;
   endfunction

   function automatic logic [31:0] make_ident_word(input logic [7:0] prod,
                                                   input logic [3:0] rev,
                                                   input logic [11:0] impl);
      logic [31:0] w;
      w = '0;
      w[31:24] = prod;
      w[15:12] = rev;
      w[11:0]  = impl;
      return w;
   endfunction

endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
   import irq_dist_pkg::*;
(
   input  logic [1:0] word_field,
   input  logic       we,
   output word_sel_t  sel,
   output logic       ctrl_wr,
   output logic       ident_wr
);
   always_comb begin
      sel      = word_sel_t'(word_field);
      ctrl_wr  = we && (sel == WSEL_CTRL);
      ident_wr = we && (sel == WSEL_IDENT);
   end
endmodule

// File: rtl/irq_dist_readmux.sv
module irq_dist_readmux
   import irq_dist_pkg::*;
#(
   parameter logic [31:0] TYPE_WORD  = 32'h0,
   parameter logic [31:0] IDENT_WORD = 32'h0
) (
   input  word_sel_t   sel,
   input  logic        en,
   output logic [31:0] rdata
);
   always_comb begin
      rdata = '0;
      unique case (sel)
         WSEL_CTRL:  rdata[EN_BIT] = en;
         WSEL_TYPE:  rdata = TYPE_WORD;
         WSEL_IDENT: rdata = IDENT_WORD;
         WSEL_NONE:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_dist_enable.sv
module irq_dist_enable #(
   parameter int unsigned NUM_CPU = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_val,
   input  logic               cfg_wr,
   input  logic               cfg_val,
   output logic               en,
   output logic [NUM_CPU-1:0] wake
);
   logic en_next;

   always_comb begin
      en_next = en;
      if (cfg_wr)
         en_next = cfg_val;
      else if (bus_wr)
         en_next = bus_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         wake <= '0;
      end else begin
         en   <= en_next;
         wake <= {NUM_CPU{en_next & ~en}};
      end
   end
endmodule

// File: rtl/irq_dist_unlock.sv
module irq_dist_unlock #(
   parameter logic [31:0] IDENT_WORD = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ident_wr,
   input  logic [31:0] wdata,
   output logic        unlocked,
   output logic        err
);
   logic match;
   assign match = (wdata == IDENT_WORD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         err      <= 1'b0;
      end else begin
         err <= ident_wr && !match;
         if (ident_wr && match)
            unlocked <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_dist_group_bank.sv
module irq_dist_group_bank #(
   parameter int unsigned NUM_IRQ = 96,
   parameter int unsigned IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               allow,
   input  logic [IDX_W-1:0]   idx,
   input  logic [31:0]        wdata,
   output logic [NUM_IRQ-1:0] bits
);
   localparam int unsigned NUM_WORDS = NUM_IRQ / 32;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic hit;
      assign hit = wr && allow && (idx == IDX_W'(w));
      always_ff @(posedge clk) begin
         if (!rst_n)
            bits[32*w +: 32] <= '0;
         else if (hit)
            bits[32*w +: 32] <= wdata;
      end
   end
endmodule

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl
   import irq_dist_pkg::*;
#(
   parameter int unsigned NUM_IRQ     = 96,
   parameter int unsigned NUM_CPU     = 4,
   parameter logic [7:0]  PRODUCT_ID  = 8'h5A,
   parameter logic [3:0]  REVISION    = 4'h3,
   parameter logic [11:0] IMPLEMENTER = 12'h1C7,
   parameter int unsigned BUS_AW      = 4,
   parameter int unsigned IDX_W       = (NUM_IRQ / 32 > 1) ? $clog2(NUM_IRQ / 32) : 1,
   parameter int unsigned CFG_AW      = (IDX_W + 2 > 4) ? IDX_W + 2 : 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [BUS_AW-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               cfg_we,
   input  logic               cfg_space,
   input  logic [CFG_AW-1:0]  cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic               cfg_err,
   output logic               dist_en,
   output logic [NUM_CPU-1:0] wake_pulse,
   output logic               group_unlocked,
   output logic [NUM_IRQ-1:0] grp_bits
);
   localparam logic [31:0] TYPE_WORD  = make_type_word(NUM_IRQ, NUM_CPU);
   localparam logic [31:0] IDENT_WORD = make_ident_word(PRODUCT_ID, REVISION, IMPLEMENTER);

   if (NUM_IRQ % 32 != 0 || NUM_IRQ < 32 || NUM_IRQ > 1024) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 32 in 32..1024");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be in 1..8");
   end
   if (BUS_AW < 4) begin : g_bad_bus_aw
      $error("BUS_AW must be at least 4");
   end
   if (CFG_AW < IDX_W + 2 || CFG_AW < 4) begin : g_bad_cfg_aw
      $error("CFG_AW too small for the group word index");
   end

   // Bits of the bus that carry no meaning for this block.
   logic bus_bits_unused;
   assign bus_bits_unused = ^{bus_wdata[31:1], bus_addr[1:0]};

   word_sel_t bus_sel, cfg_sel;
   logic      bus_ctrl_wr, bus_ident_wr;
   logic      cfg_ctrl_wr, cfg_ident_wr;
   logic      cfg_misc_we, cfg_grp_we;

   assign cfg_misc_we = cfg_we && !cfg_space;
   assign cfg_grp_we  = cfg_we &&  cfg_space;

   irq_dist_decode u_bus_dec (
      .word_field (bus_addr[3:2]),
      .we         (bus_we),
      .sel        (bus_sel),
      .ctrl_wr    (bus_ctrl_wr),
      .ident_wr   (bus_ident_wr)
   );

   irq_dist_decode u_cfg_dec (
      .word_field (cfg_addr[3:2]),
      .we         (cfg_misc_we),
      .sel        (cfg_sel),
      .ctrl_wr    (cfg_ctrl_wr),
      .ident_wr   (cfg_ident_wr)
   );

   // Identification writes from the plain bus are ignored; only the
   // privileged port takes part in the unlock handshake.
   logic sel_unused;
   assign sel_unused = bus_ident_wr ^ (^cfg_sel);

   irq_dist_readmux #(
      .TYPE_WORD  (TYPE_WORD),
      .IDENT_WORD (IDENT_WORD)
   ) u_rmux (
      .sel   (bus_sel),
      .en    (dist_en),
      .rdata (bus_rdata)
   );

   irq_dist_enable #(
      .NUM_CPU (NUM_CPU)
   ) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_wr  (bus_ctrl_wr),
      .bus_val (bus_wdata[EN_BIT]),
      .cfg_wr  (cfg_ctrl_wr),
      .cfg_val (cfg_wdata[EN_BIT]),
      .en      (dist_en),
      .wake    (wake_pulse)
   );

   irq_dist_unlock #(
      .IDENT_WORD (IDENT_WORD)
   ) u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .ident_wr (cfg_ident_wr),
      .wdata    (cfg_wdata),
      .unlocked (group_unlocked),
      .err      (cfg_err)
   );

   irq_dist_group_bank #(
      .NUM_IRQ (NUM_IRQ),
      .IDX_W   (CFG_AW - 2)
   ) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_grp_we),
      .allow (group_unlocked),
      .idx   (cfg_addr[CFG_AW-1:2]),
      .wdata (cfg_wdata),
      .bits  (grp_bits)
   );
endmodule

// File: rtl/irq_dist_ctrl_chk.sv
module irq_dist_ctrl_chk #(
   parameter int unsigned NUM_IRQ = 96,
   parameter int unsigned NUM_CPU = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dist_en,
   input logic [NUM_CPU-1:0] wake_pulse,
   input logic               group_unlocked,
   input logic [NUM_IRQ-1:0] grp_bits,
   input logic               cfg_err
);
   // R3
   wake_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|wake_pulse) |-> (dist_en && !$past(dist_en)));
   // R3
   wake_all_cpus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse == '0) || (&wake_pulse));
   // R4
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|wake_pulse) |=> (wake_pulse == '0));
   // R8
   unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      group_unlocked |=> group_unlocked);
   // R9
   locked_bits_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !group_unlocked |=> $stable(grp_bits));
   // R7
   err_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !$past(group_unlocked)) |-> !group_unlocked);
endmodule

bind irq_dist_ctrl irq_dist_ctrl_chk #(
   .NUM_IRQ (NUM_IRQ),
   .NUM_CPU (NUM_CPU)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .dist_en        (dist_en),
   .wake_pulse     (wake_pulse),
   .group_unlocked (group_unlocked),
   .grp_bits       (grp_bits),
   .cfg_err        (cfg_err)
);

// File: tb/irq_dist_ctrl_test.sv
`timescale 1ns/1ps
module irq_dist_ctrl_test;
   localparam int unsigned NI = 96;
   localparam int unsigned NC = 4;
   localparam int unsigned NW = NI / 32;
   localparam logic [31:0] EXP_TYPE  = ((NI / 32 - 1) & 32'h1F) | ((NC - 1) << 5);
   localparam logic [31:0] EXP_IDENT = (32'h5A << 24) | (32'h3 << 12) | 32'h1C7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          cfg_we = 1'b0;
   logic          cfg_space = 1'b0;
   logic [3:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          cfg_err;
   logic          dist_en;
   logic [NC-1:0] wake_pulse;
   logic          group_unlocked;
   logic [NI-1:0] grp_bits;

   int checks = 0;
   int fails  = 0;
   logic [NI-1:0] grp_model = '0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_dist_ctrl #(.NUM_IRQ(NI), .NUM_CPU(NC)) uut (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cfg_we(cfg_we), .cfg_space(cfg_space), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_err(cfg_err), .dist_en(dist_en), .wake_pulse(wake_pulse),
      .group_unlocked(group_unlocked), .grp_bits(grp_bits)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
      cfg_we = 1'b0;
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
   endtask

   task automatic cfg_wr(input logic sp, input logic [3:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_space = sp; cfg_addr = a; cfg_wdata = d;
      tick();
   endtask

   function automatic logic [31:0] exp_read(input logic [3:0] a, input logic en);
      case (a[3:2])
         2'd0: return {31'b0, en};
         2'd1: return EXP_TYPE;
         2'd2: return EXP_IDENT;
         default: return 32'h0;
      endcase
   endfunction

   task automatic sweep_reads(input string req, input logic en);
      for (int a = 0; a < 16; a++) begin
         bus_addr = 4'(a);
         #0.5;
         chk(req, bus_rdata, exp_read(4'(a), en));
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R11: no wake while in reset, state cleared
      chk("R11 wake in reset", wake_pulse, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 enable", dist_en, 0);
      chk("R11 unlock", group_unlocked, 0);
      chk("R11 group", grp_bits, 0);
      chk("R11 err", cfg_err, 0);

      // R1 R5 R6: full read sweep
      sweep_reads("R1/R5/R6 sweep", 1'b0);

      // R6: writes to read-only words ignored
      bus_wr(4'h4, 32'hFFFF_FFFF);
      bus_wr(4'h8, 32'h1234_5678);
      bus_wr(4'hC, 32'hFFFF_FFFF);
      sweep_reads("R6 after ro writes", 1'b0);
      chk("R6 enable untouched", dist_en, 0);

      // R2 R3: rise
      bus_wr(4'h1, 32'hFFFF_FFFF);
      chk("R2 enable set", dist_en, 1);
      chk("R3 wake on rise", wake_pulse, {NC{1'b1}});
      bus_addr = 4'h0; #0.5;
      chk("R2 ctrl readback", bus_rdata, 32'h1);
      tick();
      chk("R3 wake one cycle", wake_pulse, 0);

      // R4: rewrite 1 and write 0
      bus_wr(4'h0, 32'h1);
      chk("R4 no wake on rewrite", wake_pulse, 0);
      bus_wr(4'h0, 32'hFFFF_FFFE);
      chk("R2 enable cleared by bit0", dist_en, 0);
      chk("R4 no wake on fall", wake_pulse, 0);

      // R9: locked group writes
      for (int w = 0; w < 4; w++) begin
         cfg_wr(1'b1, 4'(w << 2), 32'hA5A5_0000 | 32'(w));
         chk("R9 locked drop", grp_bits, 0);
      end

      // R7: mismatching ident write
      cfg_wr(1'b0, 4'h8, EXP_IDENT ^ 32'h1);
      chk("R7 err pulse", cfg_err, 1);
      chk("R7 still locked", group_unlocked, 0);
      tick();
      chk("R7 err one cycle", cfg_err, 0);
      // bus write of matching value must not unlock
      bus_wr(4'h8, EXP_IDENT);
      chk("R6 bus ident no unlock", group_unlocked, 0);
      cfg_wr(1'b1, 4'h0, 32'hDEAD_BEEF);
      chk("R9 drop after reject", grp_bits, 0);

      // R8: matching write
      cfg_wr(1'b0, 4'h8, EXP_IDENT);
      chk("R8 unlocked", group_unlocked, 1);
      chk("R8 no err", cfg_err, 0);

      // R10: every index, including out-of-range
      for (int w = 0; w < 4; w++) begin
         logic [31:0] d;
         d = 32'h1357_0000 ^ (32'(w) * 32'h0101_0101) ^ 32'hF0F0_0F0F;
         cfg_wr(1'b1, 4'(w << 2), d);
         if (w < NW) grp_model[32*w +: 32] = d;
         chk("R10 group word", grp_bits, grp_model);
      end
      cfg_wr(1'b0, 4'h8, 32'h0);
      chk("R8 sticky after bad write", group_unlocked, 1);
      chk("R7 err after unlock", cfg_err, 1);

      // R12: privileged control write
      cfg_wr(1'b0, 4'h0, 32'h1);
      chk("R12 cfg enable", dist_en, 1);
      chk("R12 cfg wake", wake_pulse, {NC{1'b1}});
      cfg_wr(1'b0, 4'h0, 32'h0);
      chk("R12 cfg disable", dist_en, 0);
      bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h1;
      cfg_we = 1'b1; cfg_space = 1'b0; cfg_addr = 4'h0; cfg_wdata = 32'h0;
      tick();
      chk("R12 cfg wins", dist_en, 0);
      chk("R12 no wake", wake_pulse, 0);
      bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0;
      cfg_we = 1'b1; cfg_space = 1'b0; cfg_addr = 4'h0; cfg_wdata = 32'h1;
      tick();
      chk("R12 cfg wins set", dist_en, 1);
      chk("R3 wake via both", wake_pulse, {NC{1'b1}});
      sweep_reads("R1 sweep enabled", 1'b1);

      // R11: mid-run reset
      rst_n = 1'b0;
      tick();
      chk("R11 reset enable", dist_en, 0);
      chk("R11 reset unlock", group_unlocked, 0);
      chk("R11 reset group", grp_bits, 0);
      bus_wr(4'h0, 32'h1);
      chk("R11 no wake in reset", wake_pulse, 0);
      rst_n = 1'b1;
      tick();
      cfg_wr(1'b1, 4'h0, 32'hFFFF_FFFF);
      chk("R9 relocked after reset", grp_bits, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule